// File: doc/BRIEF.md
# Rotate-and-Mask Shift Unit

This block turns one source word into a result word in three steps. First it rotates the source by a 5-bit amount, to the left or to the right. Then it builds an end mask whose length is given with each operation. Finally it chooses each result bit from one of two places. Bits the mask covers come from the rotated word. Bits outside the mask are filled with zeros, with copies of a sign bit, or with the matching bits of the old destination word.

The mask can be ignored (disabled), used as built (enabled), or used complemented (inverted). A separate control bit complements the built mask before the mode applies. Together these cover field extraction, field insertion and sign-extending bit-field reads with one datapath.

The rotate, mask and fill logic is purely combinational. An output register captures the result on each cycle that the valid strobe is high.

Top module: `rm_shift_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid operation, `result_o` is all zeros and `valid_o` is low.
- R2: A result appears on `result_o` one clock after `valid_i` is high, with `valid_o` high in that same cycle. When `valid_i` is low, `valid_o` goes low on the next clock and `result_o` holds its value.
- R3: `rot_left_i`=1 rotates the source left by `rot_amt_i` (0 to 31) bit positions; `rot_left_i`=0 rotates it right by the same amount.
- R4: `mode_i` picks one of eight modes: 0 disabled/zero, 1 disabled/merge, 2 disabled/sign, 3 enabled/zero, 4 enabled/merge, 5 enabled/sign, 6 inverted/zero, 7 inverted/merge. No mode combines an inverted mask with sign fill.
- R5: A mask length k in 1..31 builds a mask whose bits k-1..0 are ones and whose other bits are zeros. A length of 0 builds a mask of all ones.
- R6: `mask_inv_i`=1 complements the built mask before the mode uses it. In the disabled modes it has no effect.
- R7: In modes 0, 1 and 2, the result equals the rotated word in all 32 bits.
- R8: Modes 6 and 7 use the complement of the mask that R5 and R6 produce.
- R9: Zero-fill modes (0, 3, 6) place zeros in every bit outside the mask.
- R10: Merge modes (1, 4, 7) take every bit outside the mask from `dst_old_i`.
- R11: Sign-fill modes (2, 5) fill every bit outside the mask with the rotated bit at the highest position the mask covers. If the mask is empty, the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| valid_i | input | 1 | Operation strobe; the operands are sampled on this cycle |
| mode_i | input | 3 | Mask and fill mode (R4) |
| rot_left_i | input | 1 | Rotate direction: 1 = left, 0 = right |
| rot_amt_i | input | 5 | Rotate amount |
| mask_len_i | input | 5 | End mask length k (0 means all ones) |
| mask_inv_i | input | 1 | Complement the built end mask |
| src_i | input | 32 | Source word |
| dst_old_i | input | 32 | Old destination word, used by the merge modes |
| valid_o | output | 1 | High in the cycle a new result is present |
| result_o | output | 32 | Registered result |

## Verification
Every result is due exactly one clock after the cycle in which `valid_i` is high, because a single register lies between the operands and `result_o`. The bench drives operands on a falling edge, lets one rising edge pass, and samples `result_o` and `valid_o` on the next falling edge. It clears `valid_i` at that same point, so the hold behaviour of R2 can be checked one edge later. The same one-cycle relation is expressed in the bound properties, which compare the result with operands taken through `$past` by one cycle.

// File: rtl/rm_shift_pkg.sv
package rm_shift_pkg;

   typedef enum logic [2:0] {
      RM_DIS_ZERO  = 3'd0,
      RM_DIS_MERGE = 3'd1,
      RM_DIS_SIGN  = 3'd2,
      RM_ENA_ZERO  = 3'd3,
      RM_ENA_MERGE = 3'd4,
      RM_ENA_SIGN  = 3'd5,
      RM_INV_ZERO  = 3'd6,
      RM_INV_MERGE = 3'd7
   } rm_mode_e;

   typedef enum logic [1:0] {
      MASK_OFF = 2'd0,
      MASK_ON  = 2'd1,
      MASK_NEG = 2'd2
   } rm_mask_use_e;

   typedef enum logic [1:0] {
      FILL_ZERO  = 2'd0,
      FILL_MERGE = 2'd1,
      FILL_SIGN  = 2'd2
   } rm_fill_e;

   typedef struct packed {
      rm_mask_use_e mask_use;
      rm_fill_e     fill;
   } rm_ctrl_t;

endpackage

// File: rtl/rm_mode_decode.sv
module rm_mode_decode
   import rm_shift_pkg::*;
(
   input  logic [2:0] mode_i,
   output rm_ctrl_t   ctrl_o
);

   always_comb begin
      ctrl_o = '{mask_use: MASK_OFF, fill: FILL_ZERO};
      unique case (rm_mode_e'(mode_i))
         RM_DIS_ZERO:  ctrl_o = '{mask_use: MASK_OFF, fill: FILL_ZERO};
         RM_DIS_MERGE: ctrl_o = '{mask_use: MASK_OFF, fill: FILL_MERGE};
         RM_DIS_SIGN:  ctrl_o = '{mask_use: MASK_OFF, fill: FILL_SIGN};
         RM_ENA_ZERO:  ctrl_o = '{mask_use: MASK_ON,  fill: FILL_ZERO};
         RM_ENA_MERGE: ctrl_o = '{mask_use: MASK_ON,  fill: FILL_MERGE};
         RM_ENA_SIGN:  ctrl_o = '{mask_use: MASK_ON,  fill: FILL_SIGN};
         RM_INV_ZERO:  ctrl_o = '{mask_use: MASK_NEG, fill: FILL_ZERO};
         RM_INV_MERGE: ctrl_o = '{mask_use: MASK_NEG, fill: FILL_MERGE};
         default:      ctrl_o = '{mask_use: MASK_OFF, fill: FILL_ZERO};
      endcase
   end

endmodule

// File: rtl/rm_rotator.sv
module rm_rotator #(
   parameter int unsigned WIDTH      = 32,
   parameter bit          ROT_STAGED = 1'b1,
   localparam int unsigned AMT_W     = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] data_i,
   input  logic             left_i,
   input  logic [AMT_W-1:0] amt_i,
   output logic [WIDTH-1:0] data_o
);

   // A left rotate by n is a right rotate by (WIDTH - n) mod WIDTH.
   logic [AMT_W-1:0] amt_right;
   assign amt_right = left_i ? (AMT_W'(0) - amt_i) : amt_i;

   if (ROT_STAGED) begin : g_staged
      logic [WIDTH-1:0] stage [AMT_W+1];
      assign stage[0] = data_i;
      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         localparam int unsigned STEP = 1 << s;
         assign stage[s+1] = amt_right[s]
                           ? {stage[s][STEP-1:0], stage[s][WIDTH-1:STEP]}
                           : stage[s];
      end
      assign data_o = stage[AMT_W];
   end else begin : g_flat
      logic [2*WIDTH-1:0] doubled;
      assign doubled = {data_i, data_i} >> amt_right;
      assign data_o  = doubled[WIDTH-1:0];
   end

endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen
   import rm_shift_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   localparam int unsigned AMT_W = $clog2(WIDTH)
) (
   input  logic [AMT_W-1:0] len_i,
   input  logic             inv_i,
   input  rm_mask_use_e     use_i,
   output logic [WIDTH-1:0] mask_o
);

   logic [WIDTH-1:0] built;
   logic             len_zero;

   assign len_zero = (len_i == '0);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign built[b] = len_zero | (AMT_W'(b) < len_i);
   end

   logic [WIDTH-1:0] adjusted;
   assign adjusted = built ^ {WIDTH{inv_i}};

   always_comb begin
      unique case (use_i)
         MASK_OFF: mask_o = '1;
         MASK_ON:  mask_o = adjusted;
         MASK_NEG: mask_o = ~adjusted;
         default:  mask_o = '1;
      endcase
   end

endmodule

// File: rtl/rm_fill_merge.sv
module rm_fill_merge
   import rm_shift_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] rot_i,
   input  logic [WIDTH-1:0] old_i,
   input  logic [WIDTH-1:0] mask_i,
   input  rm_fill_e         fill_i,
   output logic [WIDTH-1:0] data_o
);

   // Sign bit: rotated bit at the highest position inside the mask.
   logic sign_bit;
   always_comb begin
      sign_bit = 1'b0;
      for (int b = 0; b < WIDTH; b++) begin
         if (mask_i[b]) sign_bit = rot_i[b];
      end
   end

   logic [WIDTH-1:0] outside;
   always_comb begin
      unique case (fill_i)
         FILL_ZERO:  outside = '0;
         FILL_MERGE: outside = old_i;
         FILL_SIGN:  outside = {WIDTH{sign_bit}};
         default:    outside = '0;
      endcase
   end

   assign data_o = (rot_i & mask_i) | (outside & ~mask_i);

endmodule

// File: rtl/rm_shift_unit.sv
module rm_shift_unit
   import rm_shift_pkg::*;
#(
   parameter int unsigned WIDTH      = 32,
   parameter bit          ROT_STAGED = 1'b1,
   localparam int unsigned AMT_W     = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [2:0]       mode_i,
   input  logic             rot_left_i,
   input  logic [AMT_W-1:0] rot_amt_i,
   input  logic [AMT_W-1:0] mask_len_i,
   input  logic             mask_inv_i,
   input  logic [WIDTH-1:0] src_i,
   input  logic [WIDTH-1:0] dst_old_i,
   output logic             valid_o,
   output logic [WIDTH-1:0] result_o
);

   if (WIDTH < 8) begin : g_bad_width
      $error("rm_shift_unit: WIDTH must be at least 8");
   end
   if ((WIDTH & (WIDTH - 1)) != 0) begin : g_bad_pow2
      $error("rm_shift_unit: WIDTH must be a power of two");
   end

   rm_ctrl_t         ctrl;
   logic [WIDTH-1:0] rotated;
   logic [WIDTH-1:0] mask;
   logic [WIDTH-1:0] result_d;

   rm_mode_decode u_dec (
      .mode_i (mode_i),
      .ctrl_o (ctrl)
   );

   rm_rotator #(
      .WIDTH      (WIDTH),
      .ROT_STAGED (ROT_STAGED)
   ) u_rot (
      .data_i (src_i),
      .left_i (rot_left_i),
      .amt_i  (rot_amt_i),
      .data_o (rotated)
   );

   rm_mask_gen #(
      .WIDTH (WIDTH)
   ) u_mask (
      .len_i  (mask_len_i),
      .inv_i  (mask_inv_i),
      .use_i  (ctrl.mask_use),
      .mask_o (mask)
   );

   rm_fill_merge #(
      .WIDTH (WIDTH)
   ) u_fill (
      .rot_i  (rotated),
      .old_i  (dst_old_i),
      .mask_i (mask),
      .fill_i (ctrl.fill),
      .data_o (result_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         result_o <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) result_o <= result_d;
      end
   end

endmodule

// File: rtl/rm_shift_unit_chk.sv
module rm_shift_unit_chk #(
   parameter int unsigned WIDTH  = 32,
   localparam int unsigned AMT_W = $clog2(WIDTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_i,
   input logic [2:0]       mode_i,
   input logic             rot_left_i,
   input logic [AMT_W-1:0] rot_amt_i,
   input logic [AMT_W-1:0] mask_len_i,
   input logic             mask_inv_i,
   input logic [WIDTH-1:0] src_i,
   input logic [WIDTH-1:0] dst_old_i,
   input logic             valid_o,
   input logic [WIDTH-1:0] result_o
);

   p_vld_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);

   p_vld_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !valid_o);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(result_o));

   p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && mode_i == 3'd0 && rot_amt_i == '0) |=> result_o == $past(src_i));

   p_left1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && mode_i == 3'd0 && rot_left_i && rot_amt_i == AMT_W'(1))
      |=> result_o == {$past(src_i[WIDTH-2:0]), $past(src_i[WIDTH-1])});

   p_neg_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && mode_i == 3'd6 && !mask_inv_i && mask_len_i == '0) |=> result_o == '0);

   p_merge_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && mode_i == 3'd7 && !mask_inv_i && mask_len_i == '0)
      |=> result_o == $past(dst_old_i));

   p_zero_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && mode_i == 3'd3 && !mask_inv_i && mask_len_i != '0)
      |=> (result_o >> $past(mask_len_i)) == '0);

endmodule

bind rm_shift_unit rm_shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid_i    (valid_i),
   .mode_i     (mode_i),
   .rot_left_i (rot_left_i),
   .rot_amt_i  (rot_amt_i),
   .mask_len_i (mask_len_i),
   .mask_inv_i (mask_inv_i),
   .src_i      (src_i),
   .dst_old_i  (dst_old_i),
   .valid_o    (valid_o),
   .result_o   (result_o)
);

// File: tb/sim_rm_shift_unit.sv
module sim_rm_shift_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  mode_i = '0;
   logic        rot_left_i = 1'b0;
   logic [4:0]  rot_amt_i = '0;
   logic [4:0]  mask_len_i = '0;
   logic        mask_inv_i = 1'b0;
   logic [31:0] src_i = '0;
   logic [31:0] dst_old_i = '0;
   logic        valid_o;
   logic [31:0] result_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rm_shift_unit u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (valid_i),
      .mode_i     (mode_i),
      .rot_left_i (rot_left_i),
      .rot_amt_i  (rot_amt_i),
      .mask_len_i (mask_len_i),
      .mask_inv_i (mask_inv_i),
      .src_i      (src_i),
      .dst_old_i  (dst_old_i),
      .valid_o    (valid_o),
      .result_o   (result_o)
   );

   // {mode, left, amt, len, inv, src, dst, expected}
   localparam int NVEC = 15;
   localparam logic [110:0] VEC [NVEC] = '{
      {3'd0, 1'b0, 5'd4,  5'd0,  1'b0, 32'h12345678, 32'h00000000, 32'h81234567}, // R3 R7
      {3'd0, 1'b1, 5'd8,  5'd0,  1'b0, 32'h12345678, 32'h00000000, 32'h34567812}, // R3
      {3'd3, 1'b0, 5'd0,  5'd8,  1'b0, 32'hA5A5A5A5, 32'h00000000, 32'h000000A5}, // R5 R9
      {3'd4, 1'b0, 5'd0,  5'd8,  1'b0, 32'h11223344, 32'hAABBCCDD, 32'hAABBCC44}, // R10
      {3'd5, 1'b0, 5'd0,  5'd8,  1'b0, 32'h00000080, 32'h00000000, 32'hFFFFFF80}, // R11
      {3'd5, 1'b0, 5'd0,  5'd8,  1'b0, 32'h0000007F, 32'hFFFFFFFF, 32'h0000007F}, // R11
      {3'd3, 1'b0, 5'd0,  5'd0,  1'b0, 32'hDEADBEEF, 32'h00000000, 32'hDEADBEEF}, // R5
      {3'd3, 1'b0, 5'd0,  5'd4,  1'b1, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFF0}, // R6
      {3'd6, 1'b0, 5'd0,  5'd16, 1'b0, 32'h12345678, 32'h00000000, 32'h12340000}, // R8
      {3'd7, 1'b0, 5'd0,  5'd16, 1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h1234DEF0}, // R8 R10
      {3'd2, 1'b0, 5'd0,  5'd4,  1'b1, 32'h87654321, 32'h00000000, 32'h87654321}, // R6 R7
      {3'd1, 1'b1, 5'd31, 5'd3,  1'b0, 32'h00000001, 32'hFFFFFFFF, 32'h80000000}, // R3 R7
      {3'd5, 1'b0, 5'd0,  5'd4,  1'b1, 32'h80000012, 32'h00000000, 32'h8000001F}, // R11
      {3'd5, 1'b0, 5'd0,  5'd0,  1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}, // R11
      {3'd6, 1'b0, 5'd0,  5'd8,  1'b1, 32'h12345678, 32'h00000000, 32'h00000078}  // R8 R6
   };

   // Model written from the requirements.
   function automatic logic [31:0] model(input logic [2:0] md, input logic lf,
         input logic [4:0] amt, input logic [4:0] len, input logic inv,
         input logic [31:0] s, input logic [31:0] d);
      logic [31:0] r, m, o;
      logic sb;
      for (int b = 0; b < 32; b++)
         r[b] = lf ? s[(b - int'(amt) + 32) % 32] : s[(b + int'(amt)) % 32];
      for (int b = 0; b < 32; b++)
         m[b] = (len == 0) ? 1'b1 : (b < int'(len));
      if (inv) m = ~m;
      if (md <= 3'd2) m = '1;
      else if (md >= 3'd6) m = ~m;
      sb = 1'b0;
      for (int b = 31; b >= 0; b--)
         if (m[b]) begin sb = r[b]; break; end
      case (md)
         3'd1, 3'd4, 3'd7: o = d;
         3'd2, 3'd5:       o = {32{sb}};
         default:          o = '0;
      endcase
      return (r & m) | (o & ~m);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] md, input logic lf, input logic [4:0] amt,
         input logic [4:0] len, input logic inv, input logic [31:0] s, input logic [31:0] d);
      @(negedge clk);
      mode_i = md; rot_left_i = lf; rot_amt_i = amt; mask_len_i = len;
      mask_inv_i = inv; src_i = s; dst_old_i = d; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      check("R1 reset result", result_o, 32'h0);
      check("R1 reset valid", {31'b0, valid_o}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle result", result_o, 32'h0);
      check("R1 idle valid", {31'b0, valid_o}, 32'h0);

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         logic [110:0] v;
         v = VEC[i];
         apply(v[110:108], v[107], v[106:102], v[101:97], v[96], v[95:64], v[63:32]);
         check($sformatf("R4 vector %0d", i), result_o, v[31:0]);
         check("R2 valid_o after strobe", {31'b0, valid_o}, 32'h1);
      end

      // R2: hold while strobe is low, inputs changing
      apply(3'd0, 1'b0, 5'd0, 5'd0, 1'b0, 32'hCAFEF00D, 32'h0);
      held = result_o;
      check("R2 first result", held, 32'hCAFEF00D);
      src_i = 32'h0BADBEEF; mode_i = 3'd6;
      @(negedge clk);
      check("R2 hold result", result_o, held);
      check("R2 valid_o low", {31'b0, valid_o}, 32'h0);

      // R6: invert bit ignored when mask disabled
      apply(3'd0, 1'b0, 5'd3, 5'd9, 1'b1, 32'h0F0F1234, 32'h0);
      check("R6 invert ignored in disabled mode", result_o,
            model(3'd0, 1'b0, 5'd3, 5'd0, 1'b0, 32'h0F0F1234, 32'h0));

      // R3: left by n equals right by 32-n
      apply(3'd0, 1'b1, 5'd5, 5'd0, 1'b0, 32'h13579BDF, 32'h0);
      held = result_o;
      apply(3'd0, 1'b0, 5'd27, 5'd0, 1'b0, 32'h13579BDF, 32'h0);
      check("R3 left5 vs right27", result_o, held);

      // Back-to-back strobes
      @(negedge clk);
      mode_i = 3'd3; rot_left_i = 0; rot_amt_i = 0; mask_len_i = 5'd4; mask_inv_i = 0;
      src_i = 32'hFFFFFFFF; valid_i = 1'b1;
      @(negedge clk);
      check("R9 back-to-back first", result_o, 32'h0000000F);
      mask_len_i = 5'd12;
      @(negedge clk);
      valid_i = 1'b0;
      check("R5 back-to-back second", result_o, 32'h00000FFF);

      // Random sweep against the model (R3 R5 R9 R10 R11)
      for (int n = 0; n < 400; n++) begin
         logic [2:0] md; logic lf; logic [4:0] am, ln; logic iv; logic [31:0] s, d;
         md = 3'($urandom); lf = 1'($urandom); am = 5'($urandom); ln = 5'($urandom);
         iv = 1'($urandom); s = $urandom; d = $urandom;
         apply(md, lf, am, ln, iv, s, d);
         check($sformatf("R4 random mode %0d", md), result_o, model(md, lf, am, ln, iv, s, d));
      end

      // Reset in mid-run clears state (R1)
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset after use", result_o, 32'h0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule